// File: doc/BRIEF.md
# Byte-Lane Load/Store Unit with Endian Select

This block sits between a byte-addressed 32-bit core and a data memory that is one word wide. For each request it turns the byte address into a word address. It produces one write-enable per byte lane and places the store data on the correct lanes. One cycle later it picks the addressed byte out of the returned read word and extends it. Word accesses pass straight through. Byte accesses use a lane chosen from the two low address bits. A big-endian select input decides whether offset 0 is the most significant lane or the least significant lane.

The memory is assumed to have a synchronous read. Read data for a load request issued in cycle T is presented on `mem_rdata` during cycle T+1. The unit registers the lane, the extension kind and the access width of the load at the end of cycle T. It drives `load_data` from `mem_rdata` in cycle T+1, with `load_valid` high in that cycle. A word access whose low address bits are not zero is flagged as misaligned. Such an access does not reach the memory.

Top module: `bytelane_lsu`

## Requirements
- R1: For any request whose low address bits suit its width, `mem_en` is high in the request cycle and `mem_addr` equals `addr[31:2]`. With `req_valid` low, `mem_en` and `mem_we` are low and `mem_be` is 4'b0000.
- R2: A word store (`req_kind` 2'b00, `req_write` 1, `addr[1:0]` 0) drives `mem_be` = 4'b1111 and `mem_wdata` = `wdata`, in both endian modes. Write-enable bit i covers `mem_wdata[8i+7:8i]`.
- R3: A byte store (`req_kind` not 2'b00) in little-endian mode (`big_endian` 0) drives `mem_be` = 1 << `addr[1:0]`, a single bit.
- R4: A byte store in big-endian mode (`big_endian` 1) drives `mem_be` = 1 << (3 - `addr[1:0]`), a single bit.
- R5: For a byte store, all four lanes of `mem_wdata` carry `wdata[7:0]`, and `mem_we` is high.
- R6: A word access with `addr[1:0]` not 0 raises `misaligned` in the request cycle and keeps `mem_en` low, `mem_we` low and `mem_be` at 4'b0000. Byte accesses never raise `misaligned`.
- R7: `load_valid` is high exactly in the cycle after a load request that reached memory (`req_valid` 1, `req_write` 0, not misaligned), and is low in every other cycle, including after reset.
- R8: A word load returns `mem_rdata` unchanged on `load_data`, in both endian modes.
- R9: A signed byte load (`req_kind` 2'b01) returns the byte on the lane given by R3/R4 for the endian mode of the request, sign-extended to 32 bits.
- R10: An unsigned byte load (`req_kind` 2'b10, and likewise 2'b11) returns that byte zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_kind | input | 2 | 00 word, 01 signed byte, 10/11 unsigned byte |
| big_endian | input | 1 | 1 = offset 0 is the most significant lane |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Store value (byte stores use bits 7:0) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Per-lane write enable |
| mem_wdata | output | 32 | Lane-placed store word |
| misaligned | output | 1 | Unaligned word access flag |
| mem_rdata | input | 32 | Read word, valid in the cycle after the load request |
| load_valid | output | 1 | Load result present |
| load_data | output | 32 | Extracted and extended load result |

## Verification
The hardest case to reach is a byte load in which the endian mode changes between the request and the data cycle. The lane and the extension kind must come from the registered request, not from the live inputs. The stimulus toggles `big_endian` and `req_kind` in the data cycle. It also returns random read words whose selected byte has its top bit set or clear, so that a lane or extension taken from the wrong cycle shows up as a wrong value. Directed sweeps cover every offset, every kind and both endian modes. They also include misaligned word accesses, and a check that no stray `load_valid` follows one.

// File: rtl/bytelane_pkg.sv
package bytelane_pkg;
    typedef enum logic [1:0] {
        KIND_WORD  = 2'b00,
        KIND_SBYTE = 2'b01,
        KIND_UBYTE = 2'b10,
        KIND_UBYTE_ALT = 2'b11
    } access_kind_e;
endpackage

// File: rtl/bl_lane_map.sv
module bl_lane_map #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             big_endian,
    output logic [OFF_W-1:0] lane
);
    localparam logic [OFF_W-1:0] TOP_LANE = OFF_W'(LANES - 1);

    always_comb begin
        lane = big_endian ? (TOP_LANE - offset) : offset;
    end
endmodule

// File: rtl/bl_store_fmt.sv
module bl_store_fmt #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              enable,
    input  logic              is_word,
    input  logic [OFF_W-1:0]  lane,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] lane_data
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = enable && (is_word || (lane == OFF_W'(g)));
        assign lane_data[g*8 +: 8] = is_word ? wdata[g*8 +: 8] : wdata[7:0];
    end
endmodule

// File: rtl/bl_load_ext.sv
module bl_load_ext #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              is_word,
    input  logic              is_signed,
    input  logic [OFF_W-1:0]  lane,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0] picked;

    always_comb begin
        picked = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            if (lane == OFF_W'(i)) picked = rdata[i*8 +: 8];
        end
        if (is_word) result = rdata;
        else         result = {{(DATA_W-8){is_signed & picked[7]}}, picked};
    end
endmodule

// File: rtl/bytelane_lsu.sv
module bytelane_lsu
    import bytelane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [1:0]              req_kind,
    input  logic                    big_endian,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic                    mem_en,
    output logic                    mem_we,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [LANES-1:0]        mem_be,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    misaligned,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    load_valid,
    output logic [DATA_W-1:0]       load_data
);
    typedef struct packed {
        logic             pend;
        logic             word;
        logic             sign;
        logic [OFF_W-1:0] lane;
    } load_ctx_t;

    load_ctx_t ctx_d, ctx_q;

    access_kind_e     kind;
    logic             is_word;
    logic [OFF_W-1:0] req_lane;
    logic             go;

    assign kind    = access_kind_e'(req_kind);
    assign is_word = (kind == KIND_WORD);

    bl_lane_map #(.LANES(LANES)) u_map (
        .offset     (addr[OFF_W-1:0]),
        .big_endian (big_endian),
        .lane       (req_lane)
    );

    always_comb begin
        misaligned = req_valid && is_word && (addr[OFF_W-1:0] != '0);
        go         = req_valid && !misaligned;
        mem_en     = go;
        mem_we     = go && req_write;
        mem_addr   = addr[ADDR_W-1:OFF_W];

        ctx_d      = ctx_q;
        ctx_d.pend = go && !req_write;
        if (go && !req_write) begin
            ctx_d.word = is_word;
            ctx_d.sign = (kind == KIND_SBYTE);
            ctx_d.lane = req_lane;
        end
    end

    bl_store_fmt #(.DATA_W(DATA_W)) u_store (
        .enable    (mem_we),
        .is_word   (is_word),
        .lane      (req_lane),
        .wdata     (wdata),
        .be        (mem_be),
        .lane_data (mem_wdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign load_valid = ctx_q.pend;

    bl_load_ext #(.DATA_W(DATA_W)) u_load (
        .is_word   (ctx_q.word),
        .is_signed (ctx_q.sign),
        .lane      (ctx_q.lane),
        .rdata     (mem_rdata),
        .result    (load_data)
    );

    assert_word_store_be_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && is_word && addr[OFF_W-1:0] == '0) |-> (mem_be == '1))
        else $error("word store must enable every lane");

    assert_byte_store_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !is_word) |-> ($countones(mem_be) == 1 && mem_we))
        else $error("byte store must enable a single lane");

    assert_misalign_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (!mem_en && !mem_we && mem_be == '0))
        else $error("misaligned access reached memory");

    assert_load_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> load_valid)
        else $error("missing load_valid after load");

    assert_no_stray_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && !mem_we) |=> !load_valid)
        else $error("load_valid without a load");

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!mem_en && mem_be == '0))
        else $error("memory strobed while idle");
endmodule

// File: tb/bytelane_lsu_tb_top.sv
module bytelane_lsu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, big_endian;
    logic [1:0]  req_kind;
    logic [31:0] addr, wdata, mem_rdata;
    logic        mem_en, mem_we, misaligned, load_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, load_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    bytelane_lsu dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_kind(req_kind), .big_endian(big_endian), .addr(addr), .wdata(wdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .misaligned(misaligned), .mem_rdata(mem_rdata),
        .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lane_of(input logic [1:0] off, input bit big);
        return big ? 3 - int'(off) : int'(off);
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] rd, input logic [1:0] kind,
                                             input logic [1:0] off, input bit big);
        logic [7:0] b;
        if (kind == 2'b00) return rd;
        b = rd[lane_of(off, big)*8 +: 8];
        if (kind == 2'b01) return {{24{b[7]}}, b};
        return {24'h0, b};
    endfunction

    task automatic do_op(input bit wr, input logic [1:0] kind, input bit big,
                         input logic [31:0] a, input logic [31:0] wd, input logic [31:0] rd);
        bit mis;
        bit is_load;
        logic [3:0] ebe;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_kind = kind; big_endian = big;
        addr = a; wdata = wd;
        #1;
        mis = (kind == 2'b00) && (a[1:0] != 2'b00);
        is_load = !wr && !mis;
        chk(misaligned == mis, "R6 misaligned flag", {31'b0, misaligned}, {31'b0, mis});
        if (mis) begin
            chk(!mem_en && !mem_we && mem_be == 4'b0, "R6 suppressed access",
                {28'b0, mem_be}, 32'h0);
        end else begin
            chk(mem_en && mem_addr == a[31:2], "R1 word address", {2'b0, mem_addr},
                {2'b0, a[31:2]});
            if (wr) begin
                if (kind == 2'b00) begin
                    chk(mem_be == 4'hf, "R2 word store enables", {28'b0, mem_be}, 32'hf);
                    chk(mem_wdata == wd, "R2 word store data", mem_wdata, wd);
                end else begin
                    ebe = 4'b1 << lane_of(a[1:0], big);
                    chk(mem_be == ebe, big ? "R4 big-endian byte enable"
                                           : "R3 little-endian byte enable",
                        {28'b0, mem_be}, {28'b0, ebe});
                    chk(mem_we && mem_wdata == {4{wd[7:0]}}, "R5 byte replicated",
                        mem_wdata, {4{wd[7:0]}});
                end
            end else begin
                chk(!mem_we && mem_be == 4'b0, "R1 load has no write", {28'b0, mem_be}, 32'h0);
            end
        end
        @(negedge clk);
        req_valid = 0; req_write = $urandom_range(0, 1); req_kind = 2'($urandom);
        big_endian = ~big; addr = $urandom; mem_rdata = rd;
        #1;
        chk(load_valid == is_load, "R7 load_valid timing", {31'b0, load_valid},
            {31'b0, is_load});
        chk(!mem_en && mem_be == 4'b0, "R1 idle quiet", {28'b0, mem_be}, 32'h0);
        if (is_load) begin
            chk(load_data == exp_load(rd, kind, a[1:0], big),
                kind == 2'b00 ? "R8 word load" : (kind == 2'b01 ? "R9 signed byte load"
                                                                : "R10 unsigned byte load"),
                load_data, exp_load(rd, kind, a[1:0], big));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; req_valid = 0; req_write = 0; req_kind = 0; big_endian = 0;
        addr = 0; wdata = 0; mem_rdata = 0;
        #1;
        chk(load_valid == 1'b0, "R7 reset load_valid", {31'b0, load_valid}, 32'h0);
        chk(mem_en == 1'b0, "R1 reset idle", {31'b0, mem_en}, 32'h0);
        #22 rst_n = 1;
        for (int e = 0; e < 2; e++) begin
            for (int k = 0; k < 4; k++) begin
                for (int o = 0; o < 4; o++) begin
                    do_op(1'b1, 2'(k), e[0], 32'h1000_0000 | 32'(o), 32'hA1B2_C3D4, 32'h0);
                    do_op(1'b0, 2'(k), e[0], 32'h2000_0040 | 32'(o), 32'h0, 32'h80FF_7F01);
                    do_op(1'b0, 2'(k), e[0], 32'h3000_0080 | 32'(o), 32'h0, 32'h0180_FE7F);
                end
            end
        end
        for (int n = 0; n < 400; n++) begin
            do_op(1'($urandom), 2'($urandom), 1'($urandom), $urandom, $urandom, $urandom);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule